// File: doc/BRIEF.md
# Fetch-Stage Branch Direction and Target Predictor

This block sits beside the instruction fetch address register. Each cycle it takes the current fetch address and, with no clock of latency, gives back a direction guess, whether a cached target exists for that address, and the address to fetch next. The direction guess comes from a table of two-bit saturating counters. A single wrong guess does not flip a well-established direction. The cached target comes from a tagged, direct-mapped table. A branch that is predicted taken and whose target is cached therefore redirects fetch in the same cycle it is looked up.

When a branch resolves, the pipeline presents its address, the real outcome and the real destination on a separate update port. In that cycle the block raises a mispredict flag when the next address its current tables would have produced differs from the real one. On the following clock edge it moves the counter toward the real outcome and, for taken branches, refreshes the target entry. Flushing and branch resolution are done outside the block.

Top module: `fetch_predictor`

## Requirements
- R1: After reset every counter holds 01 (weakly not taken) and every target entry is invalid, so any lookup gives pred_taken=0, pred_hit=0 and pred_next_pc = lookup address + 4.
- R2: Counters use the encoding 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken, and pred_taken is the counter MSB. A valid taken update increments the indexed counter and saturates at 11.
- R3: A valid not-taken update decrements the indexed counter and saturates at 00.
- R4: From 11, one not-taken update leaves pred_taken at 1 and a second one clears it. From 00, two taken updates are needed to set it.
- R5: The target entry is written (valid, tag, target) only by a valid update whose outcome is taken. A not-taken update leaves the entry as it was.
- R6: A lookup hits only when the entry at index pc[7:2] is valid and its stored tag equals pc[31:8]. An address with the same index but a different tag misses.
- R7: pred_next_pc equals pred_target when pred_hit and pred_taken are both 1, and lookup address + 4 otherwise. pred_target is meaningful only on a hit.
- R8: mispredict is 1 during a valid update exactly when the next address predicted from the pre-update state of the update index (stored target if counter MSB is 1 and the tag hits, else upd_pc + 4) differs from the real next address (upd_target if upd_taken, else upd_pc + 4).
- R9: A lookup and an update to the same index in the same cycle give the old contents. The new contents are visible from the next cycle.
- R10: With upd_valid low, the update inputs have no effect on either table, and mispredict stays 0.
- R11: Entries are independent: an update changes only the entry selected by upd_pc[7:2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | 32 | Fetch address being looked up |
| pred_taken | output | 1 | Direction guess (counter MSB) |
| pred_hit | output | 1 | Target table holds a valid entry with matching tag |
| pred_target | output | 32 | Cached target for the lookup |
| pred_next_pc | output | 32 | Address to fetch next |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome of the resolved branch |
| upd_target | input | 32 | Real destination of the resolved branch |
| mispredict | output | 1 | Guess for the resolved branch was wrong |

## Verification
A lookup and an update can land on the same table index in one cycle. The lookup must then report the contents from before the write, and the written value must appear one cycle later. The bench provokes this collision on purpose, in directed steps and during a long sweep. In the sweep, both addresses are drawn from a small pool of four tags per index, so collisions and tag aliasing happen often. Each cycle, a bench model that changes only after the clock edge judges the lookup outputs and the mispredict flag together.

// File: rtl/fp_pkg.sv
package fp_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_e;

    // saturating step toward the resolved outcome
    function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
        logic [1:0] nxt;
        nxt = cur;
        if (taken && cur != CTR_STRONG_T)
            nxt = cur + 2'd1;
        else if (!taken && cur != CTR_STRONG_NT)
            nxt = cur - 2'd1;
        return nxt;
    endfunction

endpackage

// File: rtl/fp_ctr_table.sv
module fp_ctr_table #(
    parameter int         IDX_W = 6,
    parameter logic [1:0] INIT  = 2'b01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_a_idx,
    output logic [1:0]       rd_a,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic [1:0]       rd_b,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [1:0] ctr_q [ENTRIES];
    logic [1:0] ctr_d [ENTRIES];

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            ctr_d[i] = ctr_q[i];
        end
        if (wr_en) begin
            ctr_d[wr_idx] = fp_pkg::ctr_step(ctr_q[wr_idx], wr_taken);
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (!rst_n) ctr_q[i] <= INIT;
            else        ctr_q[i] <= ctr_d[i];
        end
    end

    assign rd_a = ctr_q[rd_a_idx];
    assign rd_b = ctr_q[rd_b_idx];

endmodule

// File: rtl/fp_tgt_table.sv
module fp_tgt_table #(
    parameter int IDX_W  = 6,
    parameter int TAG_W  = 24,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_a_idx,
    input  logic [TAG_W-1:0]  rd_a_tag,
    output logic              rd_a_hit,
    output logic [ADDR_W-1:0] rd_a_tgt,
    input  logic [IDX_W-1:0]  rd_b_idx,
    input  logic [TAG_W-1:0]  rd_b_tag,
    output logic              rd_b_hit,
    output logic [ADDR_W-1:0] rd_b_tgt,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_tgt
);
    localparam int ENTRIES = 1 << IDX_W;

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] tgt;
    } ent_t;

    ent_t ent_q [ENTRIES];
    ent_t ent_d [ENTRIES];

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            ent_d[i] = ent_q[i];
        end
        if (wr_en) begin
            ent_d[wr_idx] = '{valid: 1'b1, tag: wr_tag, tgt: wr_tgt};
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (!rst_n) ent_q[i] <= '0;
            else        ent_q[i] <= ent_d[i];
        end
    end

    assign rd_a_hit = ent_q[rd_a_idx].valid && (ent_q[rd_a_idx].tag == rd_a_tag);
    assign rd_a_tgt = ent_q[rd_a_idx].tgt;
    assign rd_b_hit = ent_q[rd_b_idx].valid && (ent_q[rd_b_idx].tag == rd_b_tag);
    assign rd_b_tgt = ent_q[rd_b_idx].tgt;

endmodule

// File: rtl/fetch_predictor.sv
module fetch_predictor #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_pc,
    output logic              pred_taken,
    output logic              pred_hit,
    output logic [ADDR_W-1:0] pred_target,
    output logic [ADDR_W-1:0] pred_next_pc,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target,
    output logic              mispredict
);
    localparam int IDX_LO = 2;
    localparam int IDX_HI = IDX_LO + IDX_W - 1;
    localparam int TAG_W  = ADDR_W - IDX_HI - 1;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    logic [IDX_W-1:0]  lk_idx, upd_idx;
    logic [TAG_W-1:0]  lk_tag, upd_tag;
    logic [1:0]        lk_ctr, upd_ctr;
    logic              upd_hit;
    logic [ADDR_W-1:0] upd_tgt_old;
    logic [ADDR_W-1:0] guess_next, real_next;
    logic              unused_low;

    assign lk_idx  = lk_pc[IDX_HI:IDX_LO];
    assign lk_tag  = lk_pc[ADDR_W-1:IDX_HI+1];
    assign upd_idx = upd_pc[IDX_HI:IDX_LO];
    assign upd_tag = upd_pc[ADDR_W-1:IDX_HI+1];
    assign unused_low = ^{lk_pc[IDX_LO-1:0], upd_pc[IDX_LO-1:0]};

    fp_ctr_table #(.IDX_W(IDX_W), .INIT(fp_pkg::CTR_WEAK_NT)) i_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (lk_idx),
        .rd_a     (lk_ctr),
        .rd_b_idx (upd_idx),
        .rd_b     (upd_ctr),
        .wr_en    (upd_valid),
        .wr_idx   (upd_idx),
        .wr_taken (upd_taken)
    );

    fp_tgt_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) i_tgt (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (lk_idx),
        .rd_a_tag (lk_tag),
        .rd_a_hit (pred_hit),
        .rd_a_tgt (pred_target),
        .rd_b_idx (upd_idx),
        .rd_b_tag (upd_tag),
        .rd_b_hit (upd_hit),
        .rd_b_tgt (upd_tgt_old),
        .wr_en    (upd_valid && upd_taken),
        .wr_idx   (upd_idx),
        .wr_tag   (upd_tag),
        .wr_tgt   (upd_target)
    );

    always_comb begin
        pred_taken   = lk_ctr[1];
        pred_next_pc = (pred_hit && pred_taken) ? pred_target : lk_pc + STEP;
        guess_next   = (upd_hit && upd_ctr[1]) ? upd_tgt_old : upd_pc + STEP;
        real_next    = upd_taken ? upd_target : upd_pc + STEP;
        mispredict   = upd_valid && (guess_next != real_next);
    end

endmodule

// File: rtl/fp_checker.sv
module fp_checker #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] lk_pc,
    input logic              pred_taken,
    input logic              pred_hit,
    input logic [ADDR_W-1:0] pred_next_pc,
    input logic              upd_valid,
    input logic [ADDR_W-1:0] upd_pc,
    input logic              upd_taken,
    input logic              mispredict,
    input logic [1:0]        upd_ctr,
    input logic              upd_hit
);
    localparam int IDX_HI = IDX_W + 1;

    // R2: taken update below saturation raises the counter by one
    a_r2_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && upd_ctr != 2'b11) ##1 (upd_pc[IDX_HI:2] == $past(upd_pc[IDX_HI:2]))
        |-> upd_ctr == $past(upd_ctr) + 2'd1);

    // R2: saturation at strong taken
    a_r2_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && upd_ctr == 2'b11) ##1 (upd_pc[IDX_HI:2] == $past(upd_pc[IDX_HI:2]))
        |-> upd_ctr == 2'b11);

    // R3: not-taken update above zero lowers the counter by one
    a_r3_dec_step: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && upd_ctr != 2'b00) ##1 (upd_pc[IDX_HI:2] == $past(upd_pc[IDX_HI:2]))
        |-> upd_ctr == $past(upd_ctr) - 2'd1);

    // R5: a not-taken update never creates a target hit
    a_r5_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && !upd_hit) ##1 (upd_pc == $past(upd_pc))
        |-> !upd_hit);

    // R10: no flag without an update
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |-> !mispredict);

    // R7: without a hit, fetch falls through
    a_r7_fallthru: assert property (@(posedge clk) disable iff (!rst_n)
        !(pred_hit && pred_taken) |-> pred_next_pc == lk_pc + ADDR_W'(4));

endmodule

bind fetch_predictor fp_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_chk (.*);

// File: tb/test_fetch_predictor.sv
module test_fetch_predictor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        pred_taken, pred_hit, mispredict;
    logic [31:0] pred_target, pred_next_pc;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // bench model of the tables
    logic [1:0]  m_ctr [64];
    logic        m_val [64];
    logic [23:0] m_tag [64];
    logic [31:0] m_tgt [64];

    always #4 clk = ~clk;

    fetch_predictor i_fetch_predictor (.*);

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // drive one cycle, compare against the model, then advance model
    task automatic cyc(input logic [31:0] lpc, input logic uv, input logic [31:0] upc,
                       input logic ut, input logic [31:0] utg, input string req);
        int li, ui;
        logic e_tk, e_hit, g_hit;
        logic [31:0] e_nx, g_nx, r_nx;
        lk_pc = lpc; upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_target = utg;
        #1;
        li = int'(lpc[7:2]);
        ui = int'(upc[7:2]);
        e_tk  = m_ctr[li][1];
        e_hit = m_val[li] && (m_tag[li] == lpc[31:8]);
        e_nx  = (e_tk && e_hit) ? m_tgt[li] : lpc + 32'd4;
        g_hit = m_val[ui] && (m_tag[ui] == upc[31:8]);
        g_nx  = (g_hit && m_ctr[ui][1]) ? m_tgt[ui] : upc + 32'd4;
        r_nx  = ut ? utg : upc + 32'd4;
        chk(req, "pred_taken", 32'(pred_taken), 32'(e_tk));
        chk(req, "pred_hit", 32'(pred_hit), 32'(e_hit));
        chk(req, "pred_next_pc", pred_next_pc, e_nx);
        if (e_hit) chk(req, "pred_target", pred_target, m_tgt[li]);
        chk(req, "mispredict", 32'(mispredict), 32'(uv && (g_nx != r_nx)));
        @(posedge clk);
        if (uv) begin
            if (ut && m_ctr[ui] != 2'b11) m_ctr[ui] = m_ctr[ui] + 2'd1;
            else if (!ut && m_ctr[ui] != 2'b00) m_ctr[ui] = m_ctr[ui] - 2'd1;
            if (ut) begin
                m_val[ui] = 1'b1; m_tag[ui] = upc[31:8]; m_tgt[ui] = utg;
            end
        end
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            m_ctr[i] = 2'b01; m_val[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state at every index
        for (int i = 0; i < 64; i++)
            cyc({22'h1, 6'(i), 2'b00}, 1'b0, '0, 1'b0, '0, "R1");

        // R2 / R4: climb to strong taken, saturate, then hysteresis on the way down
        cyc(32'h0000_1014, 1'b1, 32'h0000_1014, 1'b1, 32'h0000_4000, "R2");
        cyc(32'h0000_1014, 1'b1, 32'h0000_1014, 1'b1, 32'h0000_4000, "R2");
        cyc(32'h0000_1014, 1'b1, 32'h0000_1014, 1'b1, 32'h0000_4000, "R2");
        cyc(32'h0000_1014, 1'b0, '0, 1'b0, '0, "R2");
        cyc(32'h0000_1014, 1'b1, 32'h0000_1014, 1'b0, '0, "R4");
        cyc(32'h0000_1014, 1'b0, '0, 1'b0, '0, "R4");
        cyc(32'h0000_1014, 1'b1, 32'h0000_1014, 1'b0, '0, "R4");
        cyc(32'h0000_1014, 1'b0, '0, 1'b0, '0, "R4");
        // R3: down to strong not-taken and saturate
        for (int k = 0; k < 3; k++)
            cyc(32'h0000_1014, 1'b1, 32'h0000_1014, 1'b0, '0, "R3");
        cyc(32'h0000_1014, 1'b1, 32'h0000_1014, 1'b1, 32'h0000_4000, "R4");
        cyc(32'h0000_1014, 1'b1, 32'h0000_1014, 1'b1, 32'h0000_4000, "R4");
        cyc(32'h0000_1014, 1'b0, '0, 1'b0, '0, "R4");

        // R5: not-taken update creates no target entry
        cyc(32'h0000_2024, 1'b1, 32'h0000_2024, 1'b0, 32'h0000_9000, "R5");
        cyc(32'h0000_2024, 1'b0, '0, 1'b0, '0, "R5");

        // R6: same index, different tag misses
        cyc(32'h0000_3030, 1'b1, 32'h0000_3030, 1'b1, 32'h0000_7700, "R6");
        cyc(32'h0000_3130, 1'b0, '0, 1'b0, '0, "R6");
        cyc(32'h0000_3030, 1'b0, '0, 1'b0, '0, "R7");

        // R9: lookup and update collide on one index
        cyc(32'h0000_5040, 1'b1, 32'h0000_5040, 1'b1, 32'h0000_8800, "R9");
        cyc(32'h0000_5040, 1'b1, 32'h0000_5040, 1'b1, 32'h0000_8800, "R9");
        cyc(32'h0000_5040, 1'b0, '0, 1'b0, '0, "R9");

        // R10: update inputs with valid low change nothing
        cyc(32'h0000_5040, 1'b0, 32'h0000_5040, 1'b0, 32'h0000_1234, "R10");
        cyc(32'h0000_5040, 1'b0, 32'h0000_5040, 1'b1, 32'h0000_5678, "R10");
        cyc(32'h0000_5040, 1'b0, '0, 1'b0, '0, "R10");

        // R8 / R11: sweep with four tags per index and frequent collisions
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] a, b, t;
            a = {22'h0, 2'($urandom), 6'($urandom), 2'b00};
            b = ($urandom % 4 == 0) ? a : {22'h0, 2'($urandom), 6'($urandom), 2'b00};
            t = {16'h0, 14'($urandom % 4), 2'b00} + 32'h0000_C000;
            cyc(a, 1'($urandom), b, 1'($urandom), t, (n % 2 == 0) ? "R8" : "R11");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule